// File: doc/BRIEF.md
# Guarded Mantissa Rounding Unit

This block is the rounding step that sits between a wide arithmetic datapath and the packing logic that forms the final floating-point word. It accepts an unsigned mantissa whose two lowest bits are a guard bit and a round bit. It also takes a separately carried sticky bit, the sign of the value and a 2-bit rounding direction. The guard and round bits are removed. From those bits, the sticky bit, the sign and the direction, the block decides whether to add one to what remains, and the increment carries across the full remaining width.

The result is registered once, so the outputs appear one clock after the inputs. There are three outputs: the rounded mantissa, a flag that says the increment was applied, and an inexact flag that says some precision was discarded. A consumer uses the rounded-up flag together with the mantissa value to spot a carry into the next binade. Renormalising that carry, adjusting the exponent and packing the word all remain the consumer's job.

Top module: `mant_round_unit`

## Requirements
- R1: When no increment is applied, `mant_q` equals `mant_d` shifted right by two bits (bits `mant_d[W-1:2]`). The sticky input never alters the kept bits.
- R2: When guard (`mant_d[1]`), round (`mant_d[0]`) and `sticky_d` are all 0, the result is exact: both `inexact_q` and `up_q` are 0, in every mode.
- R3: `inexact_q` is 1 exactly when at least one of guard, round or sticky is 1, whatever the mode.
- R4: In mode `2'b00` (nearest, ties to even), the increment is applied only when guard is 1 and at least one of these is 1: round, sticky, or the LSB of the kept mantissa (`mant_d[2]`).
- R5: In mode `2'b01` (toward zero), the increment is never applied.
- R6: In mode `2'b10` (toward plus infinity), the increment is applied only for an inexact value with `sign_d` = 0. In mode `2'b11` (toward minus infinity), it is applied only for an inexact value with `sign_d` = 1.
- R7: The increment adds one at the LSB of the kept mantissa and carries through every bit of it. An all-ones kept mantissa wraps to zero, and no bit outside the output is used.
- R8: `up_q` is 1 exactly when `mant_q` equals the kept mantissa plus one.
- R9: The outputs are registered and reflect the inputs of the previous clock edge. While `rst` is 1, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mant_d | input | MANT_W (128) | Mantissa; bit 1 is guard, bit 0 is round |
| sticky_d | input | 1 | OR of all bits below the round bit |
| sign_d | input | 1 | Sign of the value, 1 = negative |
| mode_d | input | 2 | Rounding direction: 00 nearest, 01 zero, 10 +inf, 11 -inf |
| mant_q | output | MANT_W-2 (126) | Rounded mantissa |
| up_q | output | 1 | The increment was applied |
| inexact_q | output | 1 | Guard, round or sticky was non-zero |

## Verification
The hardest case to reach from the ports is a carry that ripples across every chunk boundary of the incrementer. Random mantissas almost never contain the long run of ones that this needs. The stimulus therefore builds mantissas by hand: low runs of ones spanning more than three chunks, and one fully-ones kept value that must wrap to zero. Exact ties in nearest mode are also built by hand, with guard set and round and sticky clear, for both an even and an odd LSB. Randomised vectors then cover the sign and mode combinations.

// File: rtl/mant_round_pkg.sv
package mant_round_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_POS_INF = 2'b10,
        RM_NEG_INF = 2'b11
    } round_mode_e;

endpackage

// File: rtl/mant_round_decide.sv
module mant_round_decide
    import mant_round_pkg::*;
(
    input  logic       guard_b,
    input  logic       round_b,
    input  logic       sticky_b,
    input  logic       lsb_b,
    input  logic       sign_b,
    input  logic [1:0] mode,
    output logic       bump,
    output logic       lossy
);

    round_mode_e mode_e;

    always_comb begin
        mode_e = round_mode_e'(mode);
        lossy  = guard_b | round_b | sticky_b;
        unique case (mode_e)
            RM_NEAREST: bump = guard_b & (round_b | sticky_b | lsb_b);
            RM_ZERO:    bump = 1'b0;
            RM_POS_INF: bump = lossy & ~sign_b;
            RM_NEG_INF: bump = lossy & sign_b;
            default:    bump = guard_b & (round_b | sticky_b | lsb_b);
        endcase
    end

endmodule

// File: rtl/mant_round_incr.sv
module mant_round_incr #(
    parameter int W  = 126,
    parameter int CW = 32
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] y
);

    localparam int NCH = (W + CW - 1) / CW;
    localparam int LO_LAST = (NCH - 1) * CW;
    localparam int LW = W - LO_LAST;

    logic [NCH-1:0] c;

    assign c[0] = cin;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chunk
            if (g < NCH - 1) begin : g_full
                assign {c[g+1], y[g*CW +: CW]} =
                    {1'b0, a[g*CW +: CW]} + {{CW{1'b0}}, c[g]};
            end else begin : g_last
                assign y[W-1:LO_LAST] = a[W-1:LO_LAST] + LW'(c[g]);
            end
        end
    endgenerate

endmodule

// File: rtl/mant_round_unit.sv
module mant_round_unit
    import mant_round_pkg::*;
#(
    parameter int MANT_W  = 128,
    parameter int CHUNK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MANT_W-1:0] mant_d,
    input  logic              sticky_d,
    input  logic              sign_d,
    input  logic [1:0]        mode_d,
    output logic [MANT_W-3:0] mant_q,
    output logic              up_q,
    output logic              inexact_q
);

    localparam int KW = MANT_W - 2;

    logic [KW-1:0] kept;
    logic [KW-1:0] bumped;
    logic          bump;
    logic          lossy;
    logic          primed_q;

    assign kept = mant_d[MANT_W-1:2];

    mant_round_decide u_decide (
        .guard_b  (mant_d[1]),
        .round_b  (mant_d[0]),
        .sticky_b (sticky_d),
        .lsb_b    (mant_d[2]),
        .sign_b   (sign_d),
        .mode     (mode_d),
        .bump     (bump),
        .lossy    (lossy)
    );

    mant_round_incr #(.W(KW), .CW(CHUNK_W)) u_incr (
        .a   (kept),
        .cin (bump),
        .y   (bumped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mant_q    <= '0;
            up_q      <= 1'b0;
            inexact_q <= 1'b0;
            primed_q  <= 1'b0;
        end else begin
            mant_q    <= bumped;
            up_q      <= bump;
            inexact_q <= lossy;
            primed_q  <= 1'b1;
        end
    end

    AST_KEEP_SHIFT: assert property (@(posedge clk) disable iff (rst)
        primed_q && !up_q |-> mant_q == $past(mant_d[MANT_W-1:2])); // R1
    AST_EXACT_QUIET: assert property (@(posedge clk) disable iff (rst)
        primed_q && $past(mant_d[1:0] == 2'b00 && !sticky_d) |-> !inexact_q && !up_q); // R2
    AST_INEXACT_SRC: assert property (@(posedge clk) disable iff (rst)
        primed_q |-> inexact_q == $past(mant_d[1] | mant_d[0] | sticky_d)); // R3
    AST_ZERO_NO_UP: assert property (@(posedge clk) disable iff (rst)
        primed_q && $past(mode_d == 2'b01) |-> !up_q); // R5
    AST_DIRECTED_SIGN: assert property (@(posedge clk) disable iff (rst)
        primed_q && $past(mode_d[1]) && up_q |-> $past(sign_d) == $past(mode_d[0])); // R6
    AST_UP_VALUE: assert property (@(posedge clk) disable iff (rst)
        primed_q && up_q |-> mant_q == $past(mant_d[MANT_W-1:2]) + 1'b1); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> mant_q == '0 && !up_q && !inexact_q); // R9

endmodule

// File: tb/mant_round_unit_tb.sv
`timescale 1ns/1ps
module mant_round_unit_tb;

    localparam int MW = 128;
    localparam int KW = MW - 2;

    typedef struct {
        logic [KW-1:0] mant;
        logic          up;
        logic          inx;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [MW-1:0] mant_d = '0;
    logic          sticky_d = 1'b0;
    logic          sign_d = 1'b0;
    logic [1:0]    mode_d = 2'b00;
    logic [KW-1:0] mant_q;
    logic          up_q;
    logic          inexact_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    mant_round_unit u_dut (
        .clk(clk), .rst(rst), .mant_d(mant_d), .sticky_d(sticky_d),
        .sign_d(sign_d), .mode_d(mode_d),
        .mant_q(mant_q), .up_q(up_q), .inexact_q(inexact_q)
    );

    function automatic exp_t model(logic [MW-1:0] m, logic s, logic sg,
                                   logic [1:0] md, string req);
        exp_t e;
        logic g, r, lsb, inc, inx;
        g   = m[1];
        r   = m[0];
        lsb = m[2];
        inx = g | r | s;
        case (md)
            2'b00:   inc = g && (r || s || lsb);
            2'b01:   inc = 1'b0;
            2'b10:   inc = inx && !sg;
            default: inc = inx && sg;
        endcase
        e.mant = m[MW-1:2] + (inc ? 1 : 0);
        e.up   = inc;
        e.inx  = inx;
        e.req  = req;
        return e;
    endfunction

    task automatic drive(logic [MW-1:0] m, logic s, logic sg, logic [1:0] md,
                         string req);
        @(negedge clk);
        mant_d   = m;
        sticky_d = s;
        sign_d   = sg;
        mode_d   = md;
        sb.push_back(model(m, s, sg, md, req));
    endtask

    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (mant_q !== e.mant || up_q !== e.up || inexact_q !== e.inx) begin
                errors++;
                $display("FAIL %s: got mant=%h up=%b inx=%b expected mant=%h up=%b inx=%b",
                         e.req, mant_q, up_q, inexact_q, e.mant, e.up, e.inx);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++; // R9 reset state
        if (mant_q !== '0 || up_q !== 1'b0 || inexact_q !== 1'b0) begin
            errors++;
            $display("FAIL R9: got mant=%h up=%b inx=%b expected all zero",
                     mant_q, up_q, inexact_q);
        end
        @(negedge clk);
        rst = 1'b0;

        // R2 exact values in every mode
        for (int md = 0; md < 4; md++)
            drive({32'h1234_5678, 32'h9abc_def0, 32'h0f0f_0f0f, 32'h8000_0004}, 1'b0,
                  md[0], md[1:0], "R2");
        // R1 truncation with sticky only, toward zero
        drive({96'h0, 32'hffff_fff4}, 1'b1, 1'b0, 2'b01, "R1");
        // R4 nearest cases
        drive({96'h0, 32'h0000_0012}, 1'b0, 1'b0, 2'b00, "R4"); // tie, even -> no up
        drive({96'h0, 32'h0000_0016}, 1'b0, 1'b0, 2'b00, "R4"); // tie, odd -> up
        drive({96'h0, 32'h0000_0013}, 1'b0, 1'b0, 2'b00, "R4"); // guard+round
        drive({96'h0, 32'h0000_0012}, 1'b1, 1'b1, 2'b00, "R4"); // guard+sticky
        drive({96'h0, 32'h0000_0011}, 1'b1, 1'b0, 2'b00, "R4"); // no guard
        // R3 inexact from round bit only, each mode
        for (int md = 0; md < 4; md++)
            drive({96'h5, 32'h0000_0021}, 1'b0, 1'b1, md[1:0], "R3");
        // R5 toward zero with everything set
        drive({96'h0, 32'h0000_0007}, 1'b1, 1'b1, 2'b01, "R5");
        // R6 directed rounding
        drive({96'h0, 32'h0000_0040}, 1'b1, 1'b0, 2'b10, "R6");
        drive({96'h0, 32'h0000_0040}, 1'b1, 1'b1, 2'b10, "R6");
        drive({96'h0, 32'h0000_0041}, 1'b0, 1'b1, 2'b11, "R6");
        drive({96'h0, 32'h0000_0041}, 1'b0, 1'b0, 2'b11, "R6");
        // R7 carry across all chunk boundaries and wrap
        drive({28'h0, {100{1'b1}}}, 1'b0, 1'b0, 2'b00, "R7");
        drive({{126{1'b1}}, 2'b11}, 1'b0, 1'b0, 2'b00, "R7");
        drive({{30{1'b0}}, {96{1'b1}}, 2'b10}, 1'b0, 1'b1, 2'b11, "R7");
        // R8 rounded-up flag against value on random vectors
        for (int i = 0; i < 60; i++)
            drive({$urandom, $urandom, $urandom, $urandom}, 1'($urandom),
                  1'($urandom), 2'($urandom), "R8");
        @(negedge clk);
        mant_d = '0;
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule